// File: doc/BRIEF.md
# Framebuffer Word-to-Pixel Unpacker

This block sits between a framebuffer fetch engine and a parallel display data bus. It takes 32-bit words on a valid/ready stream and turns each one into one or two pixels on a valid/ready pixel stream. Each pixel is placed on a 24-bit output that is trimmed to the display bus width in use.

Three static control fields set the behaviour. A 2-bit pixel-size code picks the format: code 0 gives 16-bit pixels packed two per word, and code 3 gives 24-bit pixels stored one per word in the low three bytes. A 2-bit bus code picks the data bus width. A 4-bit byte-valid mask, bit k covering byte k of the word, decides which parts of each word are kept. An illegal or inconsistent setting latches an error that silences the block until reset. A synchronous flush drops a half-used word.

Top module: `pix_unpack`

## Requirements
- R1: After reset with a legal configuration, out_valid is 0, in_ready is 1 and cfg_err is 0.
- R2: With pixel-size code 0, bus code 0 and mask 0xF, each word yields two pixels: bits 15:0 first, then bits 31:16. Each pixel appears on out_bus[15:0] with out_bus[23:16] at zero.
- R3: With pixel-size code 3, bus code 3 and mask 0x7, each word yields exactly one pixel equal to word bits 23:0. Bits 31:24 are ignored.
- R4: In 16-bit mode, the low halfword is emitted only when mask bits 1:0 are both set, and the high halfword only when mask bits 3:2 are both set. A word with neither halfword valid is consumed and produces no pixel.
- R5: In 24-bit mode, each of bytes 0 to 2 whose mask bit is clear appears as zero in the pixel.
- R6: in_ready is 0 while the held word still has pixels that have not been taken. The one exception is the cycle in which its last pixel is taken, so a new word can be accepted in that same cycle.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_bus stays unchanged on the next cycle.
- R8: A pixel-size code of 1 or 2 sets cfg_err in the same cycle. cfg_err stays set until reset. While it is set, out_valid and in_ready are 0.
- R9: A bus code that does not match the format also sets cfg_err. The 16-bit format requires bus code 0 (16 bits) and the 24-bit format requires bus code 3 (24 bits). Bus codes 1 and 2 mean 8 and 18 bits.
- R10: While flush is 1, in_ready and out_valid are 0. Any pending pixels are discarded, so on the next cycle the block is idle, with out_valid 0 and in_ready 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard the held word and return to idle |
| wlen_code | input | 2 | Pixel size: 0 = 16-bit, 3 = 24-bit |
| bus_code | input | 2 | Bus width: 0 = 16, 1 = 8, 2 = 18, 3 = 24 bits |
| byte_mask | input | 4 | Byte-valid mask, bit k covers word byte k |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Fetched framebuffer word |
| in_ready | output | 1 | Block accepts a word this cycle |
| out_valid | output | 1 | Pixel on out_bus is valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_bus | output | 24 | Pixel trimmed to the selected bus width |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
If the pending-halfword state is wrong, the error shows on the very next pixel. A halfword goes missing, appears twice, or comes out in swapped order, and any of these is seen at the first out_bus sample after the word is accepted. If the refill condition is wrong, in_ready either rises while a pixel is still held or stays low in the cycle the last pixel leaves, so the bench samples in_ready in exactly that cycle. A sticky error that is not held becomes visible as soon as the configuration returns to legal values, so the bench checks cfg_err and in_ready one cycle after that.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

   localparam logic [1:0] WL_PIX16 = 2'd0;
   localparam logic [1:0] WL_PIX24 = 2'd3;

   localparam logic [1:0] BUS_16 = 2'd0;
   localparam logic [1:0] BUS_8  = 2'd1;
   localparam logic [1:0] BUS_18 = 2'd2;
   localparam logic [1:0] BUS_24 = 2'd3;

   // Number of live data lines for a bus code.
   function automatic logic [5:0] bus_lines(input logic [1:0] code);
      case (code)
         BUS_16:  bus_lines = 6'd16;
         BUS_8:   bus_lines = 6'd8;
         BUS_18:  bus_lines = 6'd18;
         default: bus_lines = 6'd24;
      endcase
   endfunction

endpackage

// File: rtl/pu_cfg_check.sv
module pu_cfg_check
   import pix_unpack_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] wlen_code,
   input  logic [1:0] bus_code,
   output logic       mode16,
   output logic       err_now
);
   logic legal16, legal24, bad, err_q;

   assign legal16 = (wlen_code == WL_PIX16) && (bus_code == BUS_16);
   assign legal24 = (wlen_code == WL_PIX24) && (bus_code == BUS_24);
   assign bad     = !(legal16 || legal24);
   assign mode16  = (wlen_code == WL_PIX16);
   assign err_now = err_q | bad;

   always_ff @(posedge clk) begin
      if (!rst_n)   err_q <= 1'b0;
      else if (bad) err_q <= 1'b1;
   end

   // R8: once latched, the error never clears without reset
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_now |=> err_now);

endmodule

// File: rtl/pu_word_seq.sv
module pu_word_seq #(
   parameter int WORD_W = 32,
   parameter int BUS_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              halt,
   input  logic              mode16,
   input  logic [WORD_W/8-1:0] byte_mask,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BUS_W-1:0]  pix
);
   localparam int HALF_W    = WORD_W / 2;
   localparam int PIX_BYTES = BUS_W / 8;

   logic [WORD_W-1:0] word_q;
   logic [1:0]        pend_q;
   logic              sel, last, out_fire, in_fire, lo_ok, hi_ok;
   logic [1:0]        load_pend, sel_bit;
   logic [HALF_W-1:0] half;
   logic [BUS_W-1:0]  pix16, pix24;

   assign sel      = ~pend_q[0];
   assign last     = pend_q[0] ^ pend_q[1];
   assign sel_bit  = sel ? 2'b10 : 2'b01;
   assign out_valid = (|pend_q) & ~halt & ~flush;
   assign out_fire = out_valid & out_ready;
   assign in_ready = ~halt & ~flush & (~(|pend_q) | (out_fire & last));
   assign in_fire  = in_valid & in_ready;

   assign lo_ok     = &byte_mask[1:0];
   assign hi_ok     = &byte_mask[3:2];
   assign load_pend = mode16 ? {hi_ok, lo_ok} : 2'b01;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 2'b00;
         word_q <= '0;
      end else if (flush) begin
         pend_q <= 2'b00;
      end else if (in_fire) begin
         word_q <= in_word;
         pend_q <= load_pend;
      end else if (out_fire) begin
         pend_q <= pend_q & ~sel_bit;
      end
   end

   assign half  = sel ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];
   assign pix16 = {{(BUS_W-HALF_W){1'b0}}, half};

   for (genvar b = 0; b < PIX_BYTES; b++) begin : g_byte
      assign pix24[b*8 +: 8] = byte_mask[b] ? word_q[b*8 +: 8] : 8'h00;
   end

   assign pix = mode16 ? pix16 : pix24;

   // R6: no new word while a held pixel is stalled
   p_no_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
   // R10: flush leaves nothing pending
   p_flush_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);

endmodule

// File: rtl/pu_bus_map.sv
module pu_bus_map
   import pix_unpack_pkg::*;
#(
   parameter int BUS_W = 24
) (
   input  logic [1:0]       bus_code,
   input  logic [BUS_W-1:0] pix,
   output logic [BUS_W-1:0] bus
);
   logic [5:0] lines;
   assign lines = bus_lines(bus_code);

   for (genvar i = 0; i < BUS_W; i++) begin : g_line
      assign bus[i] = pix[i] & (6'(i) < lines);
   end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
   import pix_unpack_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int BUS_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [1:0]        wlen_code,
   input  logic [1:0]        bus_code,
   input  logic [3:0]        byte_mask,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BUS_W-1:0]  out_bus,
   output logic              cfg_err
);
   if (WORD_W != 32) begin : g_bad_word
      $error("pix_unpack: WORD_W must be 32");
   end
   if (BUS_W != 24) begin : g_bad_bus
      $error("pix_unpack: BUS_W must be 24");
   end

   logic mode16, err_now;
   logic [BUS_W-1:0] pix;

   pu_cfg_check u_cfg (
      .clk(clk), .rst_n(rst_n), .wlen_code(wlen_code), .bus_code(bus_code),
      .mode16(mode16), .err_now(err_now));

   pu_word_seq #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .halt(err_now),
      .mode16(mode16), .byte_mask(byte_mask), .in_valid(in_valid),
      .in_word(in_word), .in_ready(in_ready), .out_valid(out_valid),
      .out_ready(out_ready), .pix(pix));

   pu_bus_map #(.BUS_W(BUS_W)) u_map (
      .bus_code(bus_code), .pix(pix), .bus(out_bus));

   assign cfg_err = err_now;

   // R7: stalled pixel is held steady
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=> (cfg_err || (out_valid && $stable(out_bus))));
   // R8: error silences both handshakes
   p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!out_valid && !in_ready));
   // R2: 16-bit pixels leave the upper lines at zero
   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && wlen_code == WL_PIX16) |-> (out_bus[BUS_W-1:16] == '0));

endmodule

// File: tb/pix_unpack_tb_top.sv
`timescale 1ns/1ps
module pix_unpack_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [1:0]  wlen_code = 2'd0;
   logic [1:0]  bus_code = 2'd0;
   logic [3:0]  byte_mask = 4'hF;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        in_ready, out_valid, cfg_err;
   logic        out_ready = 1'b0;
   logic [23:0] out_bus;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pix_unpack dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wlen_code(wlen_code),
      .bus_code(bus_code), .byte_mask(byte_mask), .in_valid(in_valid),
      .in_word(in_word), .in_ready(in_ready), .out_valid(out_valid),
      .out_ready(out_ready), .out_bus(out_bus), .cfg_err(cfg_err));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; flush = 1'b0;
      wlen_code = 2'd0; bus_code = 2'd0; byte_mask = 4'hF;
      step(); step();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk("R1 out_valid", out_valid, 0);
      chk("R1 in_ready", in_ready, 1);
      chk("R1 cfg_err", cfg_err, 0);
   endtask

   task automatic t_pack16();
      in_valid = 1; in_word = 32'hAAAA_5555; #1;
      chk("R6 ready idle", in_ready, 1);
      step(); in_valid = 0; #1;
      chk("R2 valid", out_valid, 1);
      chk("R2 low first", out_bus, 32'h005555);
      chk("R6 busy", in_ready, 0);
      step(); #1;
      chk("R7 held valid", out_valid, 1);
      chk("R7 held data", out_bus, 32'h005555);
      out_ready = 1;
      step(); #1;
      chk("R2 high second", out_bus, 32'h00AAAA);
      chk("R6 refill on last", in_ready, 1);
      in_valid = 1; in_word = 32'h1234_5678;
      step(); in_valid = 0; #1;
      chk("R2 refill low", out_bus, 32'h005678);
      step(); #1;
      chk("R2 refill high", out_bus, 32'h001234);
      step(); #1;
      chk("R2 drained", out_valid, 0);
      out_ready = 0;
   endtask

   task automatic t_pix24();
      wlen_code = 2'd3; bus_code = 2'd3; byte_mask = 4'h7;
      out_ready = 1; in_valid = 1; in_word = 32'hFFAB_CDEF;
      step(); in_valid = 0; #1;
      chk("R3 pixel", out_bus, 32'hABCDEF);
      chk("R3 ready with last", in_ready, 1);
      step(); #1;
      chk("R3 one per word", out_valid, 0);
      byte_mask = 4'h5; in_valid = 1; in_word = 32'h0011_2233;
      step(); in_valid = 0; #1;
      chk("R5 byte1 zeroed", out_bus, 32'h110033);
      step();
      out_ready = 0; byte_mask = 4'hF; wlen_code = 2'd0; bus_code = 2'd0;
   endtask

   task automatic t_mask16();
      out_ready = 1; byte_mask = 4'hC; in_valid = 1; in_word = 32'hBEEF_1234;
      step(); in_valid = 0; #1;
      chk("R4 high only", out_bus, 32'h00BEEF);
      step(); #1;
      chk("R4 single pixel", out_valid, 0);
      byte_mask = 4'h3; in_valid = 1; in_word = 32'hBEEF_1234;
      step(); in_valid = 0; #1;
      chk("R4 low only", out_bus, 32'h001234);
      step(); #1;
      chk("R4 single low", out_valid, 0);
      byte_mask = 4'h6; in_valid = 1; in_word = 32'hCAFE_F00D;
      step(); in_valid = 0; #1;
      chk("R4 none valid", out_valid, 0);
      chk("R4 consumed", in_ready, 1);
      out_ready = 0; byte_mask = 4'hF;
   endtask

   task automatic t_flush();
      in_valid = 1; in_word = 32'h7777_6666;
      step(); in_valid = 0; #1;
      chk("R10 loaded", out_valid, 1);
      flush = 1; #1;
      chk("R10 valid low", out_valid, 0);
      chk("R10 ready low", in_ready, 0);
      step(); flush = 0; #1;
      chk("R10 idle valid", out_valid, 0);
      chk("R10 idle ready", in_ready, 1);
   endtask

   task automatic t_errors();
      bus_code = 2'd3; #1;
      chk("R9 mismatch", cfg_err, 1);
      chk("R9 ready low", in_ready, 0);
      do_reset(); #1;
      chk("R1 cleared", cfg_err, 0);
      wlen_code = 2'd2; #1;
      chk("R8 bad code", cfg_err, 1);
      step(); wlen_code = 2'd0; in_valid = 1; in_word = 32'h1111_2222; #1;
      chk("R8 sticky", cfg_err, 1);
      chk("R8 ready low", in_ready, 0);
      step(); in_valid = 0; #1;
      chk("R8 no pixel", out_valid, 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_pack16();
      t_pix24();
      t_mask16();
      t_flush();
      t_errors();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule